// File: doc/BRIEF.md
# Octal Low-Side Channel Fault Latch and Diagnostic Encoder

This block is the digital control core for eight low-side power switches. Each cycle it turns a registered serial control byte into per-channel gate enables. On channels 0 and 1 it also takes an active-low direct drive input, which is ORed with the serial bit. The block watches a digital comparator flag for each channel that reports "output voltage above threshold". When an enabled channel 0 to 5 stays above threshold for a programmable number of microsecond ticks, the channel is latched off. Channels 6 and 7 latch off on an over-temperature flag instead.

A latched channel stays off until its command goes off and then on again, or until reset. Every channel produces a diagnostic bit. Normally this bit is a status bit that mirrors the comparator. When channel 0 or 1 is driven from its direct input, the bit becomes an active-low fault bit. That bit is held at "no fault" during a blanking window after any edge on the direct input, and overload detection on that channel is suspended for the same window.

Both output vectors are registered. A change on an input shows at the outputs one clock later.

Top module: `octal_sink_ctrl`

## Requirements
- R1: Channels 0 and 1 are commanded off only when their serial bit `ctl_bits[c]` is 0 and their direct input `dir_n[c]` is 1. Every other combination commands them on.
- R2: Channels 2 to 7 are commanded on when `ctl_bits[c]` is 1 and off when it is 0.
- R3: For channels 0 to 5, an enabled channel whose `above_thr[c]` is high on SHUT_US consecutive `us_tick` cycles is latched off. The gate drops one clock after the SHUT_US-th tick and never before it. The count restarts whenever the condition lapses.
- R4: A latched channel stays off while its command stays on, even after the comparator flag clears. It turns on again only after its command has gone off and then come back on.
- R5: Channel 6 latches off one clock after `ovt[0]` is high while it is commanded on, and channel 7 does the same on `ovt[1]`. The comparator flag never trips these two channels.
- R6: In status mode the diagnostic bit equals the comparator flag: 1 for above threshold, 0 for below, whether the channel is on or off. On channels 6 and 7 the bit is also 1 while the thermal latch is set.
- R7: Channel 0 or 1 is in direct mode when its serial bit is 0. In that mode its diagnostic bit is 0 (fault) when the gate state and the comparator disagree in the faulty sense, that is on and above or off and below. It is 1 (no fault) when the channel is on and below or off and above.
- R8: For BLANK_US ticks after an edge on `dir_n[c]`, counted from the clock after the edge is seen, channel c does not count overload and its direct-mode diagnostic bit is held at 1.
- R9: While `rst` is high, all gate enables and diagnostic bits are 0 and all fault latches and timers are cleared.
- R10: Gate enables and diagnostic bits are registered. Each reflects the inputs seen at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ctl_bits | input | 8 | Serial control byte, one bit per channel |
| dir_n | input | 2 | Active-low direct drive inputs for channels 0 and 1 |
| above_thr | input | 8 | Comparator flag per channel: output above threshold |
| ovt | input | 2 | Over-temperature flags for channels 6 and 7 |
| gate_en | output | 8 | Gate enable per channel |
| diag | output | 8 | Diagnostic bit per channel |

## Verification
On every cycle the assertions check the reset values, the off command for the plain and direct channels, the immediate thermal shutdown, and the status bits of channels 2 to 5 tracking the comparator one clock later. The bench's scenarios are the only way to show the timing behaviours. These are the overload delay counted in ticks, persistence of the latch until an off-then-on command, the direct-mode fault encoding, and the blanking window that postpones a trip and masks the fault bit. The bench drives these directed cases and then runs a long random run compared against a cycle model.

// File: rtl/drv_pkg.sv
package drv_pkg;
  typedef enum logic [1:0] {CH_PLAIN, CH_DIRECT, CH_THERM} ch_kind_e;

  localparam int NCH        = 8;
  localparam int NDIR       = 2;
  localparam int NTHERM     = 2;
  localparam int THERM_BASE = NCH - NTHERM;

  function automatic ch_kind_e kind_of(input int idx);
    if (idx < NDIR)        return CH_DIRECT;
    if (idx >= THERM_BASE) return CH_THERM;
    return CH_PLAIN;
  endfunction
endpackage

// File: rtl/drv_blank.sv
module drv_blank #(
  parameter int BLANK_US = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic dir_n,
  output logic blank
);
  localparam int BW = $clog2(BLANK_US + 1);

  logic          prev_q;
  logic [BW-1:0] left_q;
  logic          chg;

  assign chg   = dir_n ^ prev_q;
  assign blank = chg | (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= dir_n;
      left_q <= '0;
    end else begin
      prev_q <= dir_n;
      if (chg)
        left_q <= BW'(BLANK_US);
      else if (tick && left_q != '0)
        left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/drv_otimer.sv
module drv_otimer #(
  parameter int SHUT_US = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sense,
  output logic expire
);
  localparam int CW = $clog2(SHUT_US + 1);
  localparam logic [CW-1:0] LAST = CW'(SHUT_US - 1);

  logic [CW-1:0] cnt_q;

  assign expire = sense & tick & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !sense)
      cnt_q <= '0;
    else if (tick && cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/octal_sink_ctrl.sv
module octal_sink_ctrl
  import drv_pkg::*;
#(
  parameter int SHUT_US  = 8,
  parameter int BLANK_US = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick,
  input  logic [NCH-1:0]   ctl_bits,
  input  logic [NDIR-1:0]  dir_n,
  input  logic [NCH-1:0]   above_thr,
  input  logic [NTHERM-1:0] ovt,
  output logic [NCH-1:0]   gate_en,
  output logic [NCH-1:0]   diag
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam ch_kind_e K = kind_of(c);

    logic cmd, dir_mode, blank, sense, trip, flt_q, flt_d;
    logic gate_q, diag_q, diag_d;

    if (K == CH_DIRECT) begin : g_dir
      drv_blank #(.BLANK_US(BLANK_US)) u_blk (
        .clk   (clk),
        .rst   (rst),
        .tick  (us_tick),
        .dir_n (dir_n[c]),
        .blank (blank)
      );
      assign cmd      = ctl_bits[c] | ~dir_n[c];
      assign dir_mode = ~ctl_bits[c];
    end else begin : g_ser
      assign blank    = 1'b0;
      assign cmd      = ctl_bits[c];
      assign dir_mode = 1'b0;
    end

    assign sense = gate_q & above_thr[c] & ~blank;

    if (K == CH_THERM) begin : g_therm
      assign trip = ovt[c - THERM_BASE];
    end else begin : g_oc
      drv_otimer #(.SHUT_US(SHUT_US)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .tick   (us_tick),
        .sense  (sense),
        .expire (trip)
      );
    end

    assign flt_d = cmd & (flt_q | trip);

    always_comb begin
      if (dir_mode)
        diag_d = blank ? 1'b1 : (above_thr[c] ^ gate_q);
      else if (K == CH_THERM)
        diag_d = above_thr[c] | flt_q;
      else
        diag_d = above_thr[c];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flt_q  <= 1'b0;
        gate_q <= 1'b0;
        diag_q <= 1'b0;
      end else begin
        flt_q  <= flt_d;
        gate_q <= cmd & ~flt_d;
        diag_q <= diag_d;
      end
    end

    assign gate_en[c] = gate_q;
    assign diag[c]    = diag_q;
  end
endmodule

// File: rtl/octal_sink_ctrl_chk.sv
module octal_sink_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ctl_bits,
  input logic [1:0] dir_n,
  input logic [7:0] above_thr,
  input logic [1:0] ovt,
  input logic [7:0] gate_en,
  input logic [7:0] diag
);
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (gate_en == 8'h00 && diag == 8'h00));

  p_plain_off_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gate_en[7:2] & ~$past(ctl_bits[7:2])) == 6'h00));

  p_direct_off_r1: assert property (@(posedge clk) disable iff (rst)
    (!ctl_bits[0] && dir_n[0]) |=> !gate_en[0]);

  p_direct_off1_r1: assert property (@(posedge clk) disable iff (rst)
    (!ctl_bits[1] && dir_n[1]) |=> !gate_en[1]);

  p_therm_off_r5: assert property (@(posedge clk) disable iff (rst)
    (ovt[0]) |=> !gate_en[6]);

  p_therm7_off_r5: assert property (@(posedge clk) disable iff (rst)
    (ovt[1]) |=> !gate_en[7]);

  p_status_track_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (diag[5:2] == $past(above_thr[5:2])));
endmodule

bind octal_sink_ctrl octal_sink_ctrl_chk u_chk (.*);

// File: tb/sim_octal_sink_ctrl.sv
`timescale 1ns/1ps
module sim_octal_sink_ctrl;
  localparam int SHUT  = 3;
  localparam int BLANK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic us_tick = 1'b1;
  logic [7:0] ctl_bits = 8'h00;
  logic [1:0] dir_n = 2'b11;
  logic [7:0] above_thr = 8'h00;
  logic [1:0] ovt = 2'b00;
  logic [7:0] gate_en, diag;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  octal_sink_ctrl #(.SHUT_US(SHUT), .BLANK_US(BLANK)) u0 (
    .clk(clk), .rst(rst), .us_tick(us_tick), .ctl_bits(ctl_bits),
    .dir_n(dir_n), .above_thr(above_thr), .ovt(ovt),
    .gate_en(gate_en), .diag(diag));

  // cycle model built from the requirements
  logic [7:0] m_gate = 8'h00, m_diag = 8'h00, m_flt = 8'h00;
  int unsigned m_cnt [8];
  int unsigned m_left [2];
  logic [1:0] m_prev = 2'b11;

  always @(posedge clk) begin
    logic [7:0] ng, nd, nf;
    logic blk, dmode, cmd, sense, trip, fd, chg;
    if (rst) begin
      m_gate = 8'h00; m_diag = 8'h00; m_flt = 8'h00;
      for (int c = 0; c < 8; c++) m_cnt[c] = 0;
      for (int c = 0; c < 2; c++) m_left[c] = 0;
      m_prev = dir_n;
    end else begin
      for (int c = 0; c < 8; c++) begin
        blk = 1'b0; dmode = 1'b0; chg = 1'b0; cmd = ctl_bits[c];
        if (c < 2) begin
          chg   = (dir_n[c] != m_prev[c]);
          blk   = chg || (m_left[c] != 0);
          cmd   = ctl_bits[c] | ~dir_n[c];
          dmode = ~ctl_bits[c];
        end
        sense = m_gate[c] & above_thr[c] & ~blk;
        if (c >= 6) trip = ovt[c-6];
        else trip = sense && us_tick && (m_cnt[c] == SHUT-1);
        fd = cmd & (m_flt[c] | trip);
        nf[c] = fd;
        ng[c] = cmd & ~fd;
        if (dmode) nd[c] = blk ? 1'b1 : (above_thr[c] ^ m_gate[c]);
        else if (c >= 6) nd[c] = above_thr[c] | m_flt[c];
        else nd[c] = above_thr[c];
        if (!sense) m_cnt[c] = 0;
        else if (us_tick && m_cnt[c] != SHUT-1) m_cnt[c] = m_cnt[c] + 1;
        if (c < 2) begin
          if (chg) m_left[c] = BLANK;
          else if (us_tick && m_left[c] != 0) m_left[c] = m_left[c] - 1;
        end
      end
      m_prev = dir_n;
      m_gate = ng; m_diag = nd; m_flt = nf;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0451));
    step(2);
    chk("R9 gate in reset", gate_en, 8'h00);
    chk("R9 diag in reset", diag, 8'h00);
    rst = 1'b0;
    step(1);
    // R1 combinations for direct channels
    ctl_bits = 8'h00; dir_n = 2'b11; step(1);
    chk("R1 ser0 in1 off", gate_en & 8'h03, 8'h00);
    dir_n = 2'b10; step(1);
    chk("R1 ch0 direct on", gate_en & 8'h03, 8'h01);
    ctl_bits = 8'h02; dir_n = 2'b11; step(1);
    chk("R1 ch1 serial on", gate_en & 8'h03, 8'h02);
    ctl_bits = 8'h03; dir_n = 2'b00; step(1);
    chk("R1 both on", gate_en & 8'h03, 8'h03);
    // R2 plain channels
    ctl_bits = 8'hA4; dir_n = 2'b11; step(1);
    chk("R2 follow bits R10", gate_en, 8'hA4);
    step(BLANK + 2);
    // R6 status and R3 delay on ch5
    above_thr = 8'b0011_0000; step(1);
    chk("R6 status", diag & 8'h3C, 8'h30);
    step(1);
    chk("R3 not yet tripped", gate_en & 8'h20, 8'h20);
    step(1);
    chk("R3 tripped after delay", gate_en & 8'h20, 8'h00);
    above_thr = 8'h00; step(2);
    chk("R4 stays latched", gate_en & 8'h20, 8'h00);
    ctl_bits = 8'h84; step(1);
    ctl_bits = 8'hA4; step(1);
    chk("R4 off then on clears", gate_en & 8'h20, 8'h20);
    // R5 thermal ch7
    ovt = 2'b10; step(1);
    chk("R5 thermal off", gate_en & 8'h80, 8'h00);
    ovt = 2'b00; step(1);
    chk("R5 stays off", gate_en & 8'h80, 8'h00);
    chk("R6 thermal status", diag & 8'h80, 8'h80);
    ctl_bits = 8'h24; step(1);
    ctl_bits = 8'hA4; step(1);
    chk("R5 cleared by cycle", gate_en & 8'h80, 8'h80);
    // R7 direct fault bit ch1
    ctl_bits = 8'h00; dir_n = 2'b01; step(BLANK + 3);
    chk("R7 on below no fault", {gate_en[1], diag[1]}, 8'h03);
    above_thr = 8'h02; step(1);
    chk("R7 on above fault", diag & 8'h02, 8'h00);
    above_thr = 8'h00; dir_n = 2'b11; step(BLANK + 3);
    chk("R7 off below fault", diag & 8'h02, 8'h00);
    above_thr = 8'h02; step(1);
    chk("R7 off above no fault", diag & 8'h02, 8'h02);
    above_thr = 8'h00; step(2);
    // R8 blanking on ch0
    dir_n = 2'b10; above_thr = 8'h01; step(5);
    chk("R8 no trip in blank", gate_en & 8'h01, 8'h01);
    chk("R8 diag held", diag & 8'h01, 8'h01);
    step(1);
    chk("R8 fault after blank", diag & 8'h01, 8'h00);
    chk("R8 gate still on", gate_en & 8'h01, 8'h01);
    step(2);
    chk("R8 delayed trip", gate_en & 8'h01, 8'h00);
    above_thr = 8'h00; dir_n = 2'b11; step(2);
    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      us_tick = ($urandom % 3) == 0;
      if (($urandom % 8) == 0) ctl_bits = 8'($urandom);
      if (($urandom % 10) == 0) dir_n = 2'($urandom);
      if (($urandom % 2) == 0) above_thr = 8'($urandom) & 8'($urandom);
      ovt = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
      if (($urandom % 500) == 0) rst = 1'b1; else rst = 1'b0;
      step(1);
      chk("R10 gate model", gate_en, m_gate);
      chk("R10 diag model", diag, m_diag);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule